// File: doc/BRIEF.md
# Bus-Master Channel Status and Interrupt Register Bank

This block holds the software-visible control and status state for a two-channel disk bus-master engine. Each channel has a command byte whose lowest bit starts or stops the engine, and a status byte that collects the interrupt and error events the engine raises. The status byte also carries two drive capability flags and two live copies of engine state: transfer in progress and channel disabled.

Interrupt state is kept twice for each channel. One copy is the interrupt flag in the channel's status byte. The other is a pending bit in a shared mode byte, with one bit per channel. A third copy, an auxiliary flag, sits in one of two extra configuration bytes. The per-channel interrupt test output is true only when the status flag and the shared pending bit are both set. Software therefore has to clear both places to fully acknowledge an interrupt. The block also reports whether a finished transfer was good: interrupt set, no error and the engine idle.

All storage sits behind one byte-wide register port. That port has a single address, a write strobe and a read strobe. The read data and all outputs are registered.

Top module: `bm_status_regs`

## Requirements
- R1: The command byte of channel c (address 0 for channel 0, address 2 for channel 1) stores the written byte. Output `run[c]` equals its bit 0 and changes on the clock edge of the write.
- R2: In each status byte (address 1 for channel 0, address 3 for channel 1), bit 2 is set by `irq_evt[c]` and bit 1 is set by `err_evt[c]`. Writing 1 to either bit clears it. Writing 0 leaves it unchanged.
- R3: When a set event and a write-1-to-clear of the same flag fall on the same clock, the flag ends up set. This holds for the status flags, the shared pending bits and the auxiliary flags.
- R4: In the status byte, bits 6:5 are read/write drive capability flags. Bit 0 is a registered copy of `xfer_active[c]` and bit 7 is a registered copy of `chan_off[c]`. Bits 4:3 read 0. Writes have no effect on bits 0, 3, 4 and 7.
- R5: The shared mode byte (address 4) holds a pending bit for channel 0 in bit 2 and for channel 1 in bit 3. A pending bit is set by `irq_evt[c]` and cleared by writing 1 to it.
- R6: Mode byte bits 0, 4, 5, 6 and 7 are plain read/write; bits 4 and 5 are the per-channel block bits. Bit 1 accepts writes but always reads 0.
- R7: The auxiliary flag of channel 0 is bit 1 of address 5, and that of channel 1 is bit 4 of address 6. Each is set by `irq_evt[c]` and cleared by writing 1 to it. The other bits of those two bytes are plain read/write.
- R8: `irq_test[c]` is 1 exactly when, after the current edge, both the channel's status bit 2 and its shared pending bit are set. If either bit is clear, the output is 0.
- R9: `xfer_good[c]` is 1 exactly when, after the current edge, status bits 2:0 would read binary 100. That means interrupt set, error clear and `xfer_active[c]` low.
- R10: Reset (synchronous, active high) clears every register. After reset all outputs and all readable bytes are 0.
- R11: A read strobe captures, on that edge, the addressed byte as it stood before the edge. Address 7 reads 0. Without a read strobe, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | AW (3) | Register address |
| wr_data | input | DW (8) | Write byte |
| rd_data | output | DW (8) | Registered read byte |
| irq_evt | input | NCH (2) | Per-channel interrupt event pulse |
| err_evt | input | NCH (2) | Per-channel error event pulse |
| xfer_active | input | NCH (2) | Per-channel transfer in progress |
| chan_off | input | NCH (2) | Per-channel disabled indication |
| run | output | NCH (2) | Engine start bit per channel |
| irq_test | output | NCH (2) | Interrupt asserted in both places |
| xfer_good | output | NCH (2) | Transfer finished cleanly |

## Verification
On every cycle, the embedded assertions check several properties. Set events always leave their flag set on the next edge, even against a simultaneous clear. A write-1 without an event clears the flag. Each command write appears on `run`. The mode byte's write-only bit never reads back. `irq_test` and `xfer_good` are never high unless the underlying status and mirror bits agree.

Only the bench's scenarios can show some behaviours. One is that clearing the status flag alone leaves the shared pending bit, and with it the auxiliary flag, untouched, so the test output still drops while the mirror stays set. Another is that the channels are independent. The exact byte images returned for mixed writes of reserved, capability and clear bits also need the scenarios. A behavioural model compares every output on every clock through a long random phase.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;

  localparam int NCH = 2;

  // status byte bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
  localparam int ST_OFF  = 7;

  // shared mode byte
  localparam int MODE_ADDR    = 4;
  localparam int MODE_WO_POS  = 1;
  localparam int MIR_BASE     = 2;

  localparam int AUX_BASE     = 5;
  localparam int UNMAPPED     = 7;

  function automatic int cmd_addr(int c);
    return 2 * c;
  endfunction

  function automatic int stat_addr(int c);
    return 2 * c + 1;
  endfunction

  function automatic int aux_addr(int c);
    return AUX_BASE + c;
  endfunction

  function automatic int aux_flag_pos(int c);
    return (c == 0) ? 1 : 4;
  endfunction

endpackage

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
  import bm_regs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic          wr_stat,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_evt,
  input  logic          err_evt,
  input  logic          xfer_active,
  input  logic          chan_off,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] stat_byte,
  output logic          irq_q,
  output logic          err_q,
  output logic          irq_nxt,
  output logic          err_nxt
);

  logic [1:0] cap_q;
  logic       act_q;
  logic       off_q;

  // set event wins over simultaneous write-1-to-clear
  always_comb begin
    irq_nxt = irq_evt | (irq_q & ~(wr_stat & wr_data[ST_IRQ]));
    err_nxt = err_evt | (err_q & ~(wr_stat & wr_data[ST_ERR]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
      cap_q <= '0;
      act_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      if (wr_cmd)  cmd_q <= wr_data;
      if (wr_stat) cap_q <= {wr_data[ST_CAP1], wr_data[ST_CAP0]};
      irq_q <= irq_nxt;
      err_q <= err_nxt;
      act_q <= xfer_active;
      off_q <= chan_off;
    end
  end

  always_comb begin
    stat_byte          = '0;
    stat_byte[ST_ACT]  = act_q;
    stat_byte[ST_ERR]  = err_q;
    stat_byte[ST_IRQ]  = irq_q;
    stat_byte[ST_CAP0] = cap_q[0];
    stat_byte[ST_CAP1] = cap_q[1];
    stat_byte[ST_OFF]  = off_q;
  end

  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> cmd_q == $past(wr_data)); // R1

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    irq_evt |=> irq_q); // R3

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> err_q); // R3

  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wr_data[ST_IRQ] && !irq_evt) |=> !irq_q); // R2

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!err_evt && !(wr_stat && wr_data[ST_ERR])) |=> err_q == $past(err_q)); // R2

endmodule

// File: rtl/bm_irq_mirror.sv
module bm_irq_mirror
  import bm_regs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_mode,
  input  logic [NCH-1:0]          wr_aux,
  input  logic [DW-1:0]           wr_data,
  input  logic [NCH-1:0]          irq_evt,
  output logic [DW-1:0]           mode_rd,
  output logic [NCH-1:0][DW-1:0]  aux_rd,
  output logic [NCH-1:0]          mirror_q,
  output logic [NCH-1:0]          mirror_nxt,
  output logic [NCH-1:0]          ext_q
);

  function automatic logic [DW-1:0] mir_mask_f();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) m[MIR_BASE + c] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] MIR_MASK  = mir_mask_f();
  localparam logic [DW-1:0] WO_MASK   = DW'(1) << MODE_WO_POS;
  localparam logic [DW-1:0] MODE_KEEP = ~(MIR_MASK | WO_MASK);

  logic [DW-1:0] mode_cfg_q;

  always_ff @(posedge clk) begin
    if (rst)          mode_cfg_q <= '0;
    else if (wr_mode) mode_cfg_q <= wr_data & MODE_KEEP;
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      localparam int            FP        = aux_flag_pos(g);
      localparam logic [DW-1:0] FLAG_MASK = DW'(1) << FP;

      logic [DW-1:0] aux_cfg_q;
      logic          ext_nxt;

      always_comb begin
        mirror_nxt[g] = irq_evt[g] | (mirror_q[g] & ~(wr_mode & wr_data[MIR_BASE + g]));
        ext_nxt       = irq_evt[g] | (ext_q[g] & ~(wr_aux[g] & wr_data[FP]));
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mirror_q[g] <= 1'b0;
          ext_q[g]    <= 1'b0;
          aux_cfg_q   <= '0;
        end else begin
          mirror_q[g] <= mirror_nxt[g];
          ext_q[g]    <= ext_nxt;
          if (wr_aux[g]) aux_cfg_q <= wr_data & ~FLAG_MASK;
        end
      end

      always_comb begin
        aux_rd[g]     = aux_cfg_q;
        aux_rd[g][FP] = ext_q[g];
      end

      AST_MIRROR_SET: assert property (@(posedge clk) disable iff (rst)
        irq_evt[g] |=> mirror_q[g]); // R5

      AST_MIRROR_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && wr_data[MIR_BASE + g] && !irq_evt[g]) |=> !mirror_q[g]); // R5

      AST_AUX_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_aux[g] && wr_data[FP] && !irq_evt[g]) |=> !ext_q[g]); // R7

      AST_AUX_SET: assert property (@(posedge clk) disable iff (rst)
        irq_evt[g] |=> ext_q[g]); // R3
    end
  endgenerate

  always_comb begin
    mode_rd = mode_cfg_q;
    for (int c = 0; c < NCH; c++) mode_rd[MIR_BASE + c] = mirror_q[c];
  end

  AST_MODE_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> (mode_rd & MODE_KEEP) == ($past(wr_data) & MODE_KEEP)); // R6

endmodule

// File: rtl/bm_status_regs.sv
module bm_status_regs
  import bm_regs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] irq_evt,
  input  logic [NCH-1:0] err_evt,
  input  logic [NCH-1:0] xfer_active,
  input  logic [NCH-1:0] chan_off,
  output logic [NCH-1:0] run,
  output logic [NCH-1:0] irq_test,
  output logic [NCH-1:0] xfer_good
);

  logic [NCH-1:0]          wr_cmd;
  logic [NCH-1:0]          wr_stat;
  logic [NCH-1:0]          wr_aux;
  logic                    wr_mode;

  logic [NCH-1:0][DW-1:0]  cmd_q;
  logic [NCH-1:0][DW-1:0]  stat_byte;
  logic [NCH-1:0][DW-1:0]  aux_rd;
  logic [DW-1:0]           mode_rd;
  logic [NCH-1:0]          irq_q, err_q, irq_nxt, err_nxt;
  logic [NCH-1:0]          mirror_q, mirror_nxt, ext_q;
  logic [DW-1:0]           rd_nxt;

  // address decode
  always_comb begin
    wr_mode = wr_en && (addr == AW'(MODE_ADDR));
    for (int c = 0; c < NCH; c++) begin
      wr_cmd[c]  = wr_en && (addr == AW'(cmd_addr(c)));
      wr_stat[c] = wr_en && (addr == AW'(stat_addr(c)));
      wr_aux[c]  = wr_en && (addr == AW'(aux_addr(c)));
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      bm_chan_regs #(.DW(DW)) u_chan (
        .clk         (clk),
        .rst         (rst),
        .wr_cmd      (wr_cmd[g]),
        .wr_stat     (wr_stat[g]),
        .wr_data     (wr_data),
        .irq_evt     (irq_evt[g]),
        .err_evt     (err_evt[g]),
        .xfer_active (xfer_active[g]),
        .chan_off    (chan_off[g]),
        .cmd_q       (cmd_q[g]),
        .stat_byte   (stat_byte[g]),
        .irq_q       (irq_q[g]),
        .err_q       (err_q[g]),
        .irq_nxt     (irq_nxt[g]),
        .err_nxt     (err_nxt[g])
      );

      always_comb run[g] = cmd_q[g][0];

      AST_TEST_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        irq_test[g] |-> (mirror_q[g] && irq_q[g])); // R8

      AST_GOOD_IMAGE: assert property (@(posedge clk) disable iff (rst)
        xfer_good[g] |-> (irq_q[g] && !err_q[g] && !stat_byte[g][ST_ACT])); // R9
    end
  endgenerate

  bm_irq_mirror #(.DW(DW)) u_mirror (
    .clk        (clk),
    .rst        (rst),
    .wr_mode    (wr_mode),
    .wr_aux     (wr_aux),
    .wr_data    (wr_data),
    .irq_evt    (irq_evt),
    .mode_rd    (mode_rd),
    .aux_rd     (aux_rd),
    .mirror_q   (mirror_q),
    .mirror_nxt (mirror_nxt),
    .ext_q      (ext_q)
  );

  // read mux
  always_comb begin
    rd_nxt = '0;
    if (addr == AW'(MODE_ADDR)) rd_nxt = mode_rd;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(cmd_addr(c)))  rd_nxt = cmd_q[c];
      if (addr == AW'(stat_addr(c))) rd_nxt = stat_byte[c];
      if (addr == AW'(aux_addr(c)))  rd_nxt = aux_rd[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      irq_test  <= '0;
      xfer_good <= '0;
    end else begin
      if (rd_en) rd_data <= rd_nxt;
      irq_test  <= mirror_nxt & irq_nxt;
      xfer_good <= irq_nxt & ~err_nxt & ~xfer_active;
    end
  end

  AST_MODE_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(MODE_ADDR)) |=> !rd_data[MODE_WO_POS]); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(UNMAPPED)) |=> rd_data == '0); // R11

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (run == '0 && irq_test == '0 && xfer_good == '0 && rd_data == '0)); // R10

endmodule

// File: tb/tb_bm_status_regs.sv
module tb_bm_status_regs;

  localparam int NCH = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] irq_evt = '0, err_evt = '0, xfer_active = '0, chan_off = '0;
  logic [1:0] run, irq_test, xfer_good;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  always #4 clk = ~clk;

  bm_status_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_evt(irq_evt),
    .err_evt(err_evt), .xfer_active(xfer_active), .chan_off(chan_off),
    .run(run), .irq_test(irq_test), .xfer_good(xfer_good)
  );

  // behavioural reference model
  bit [7:0] m_cmd [2];
  bit       m_irq [2], m_err [2], m_act [2], m_off [2];
  bit [1:0] m_cap [2];
  bit       m_mir [2], m_ext [2];
  bit [7:0] m_aux [2];
  bit [7:0] m_mode;
  bit [7:0] m_rd;
  bit [1:0] m_itest, m_good;

  function automatic bit [7:0] m_stat(int c);
    return {m_off[c], m_cap[c], 2'b00, m_irq[c], m_err[c], m_act[c]};
  endfunction

  function automatic bit [7:0] m_read(int a);
    case (a)
      0: return m_cmd[0];
      1: return m_stat(0);
      2: return m_cmd[1];
      3: return m_stat(1);
      4: return m_mode | (8'(m_mir[0]) << 2) | (8'(m_mir[1]) << 3);
      5: return m_aux[0] | (8'(m_ext[0]) << 1);
      6: return m_aux[1] | (8'(m_ext[1]) << 4);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = 0; m_irq[c] = 0; m_err[c] = 0; m_act[c] = 0; m_off[c] = 0;
        m_cap[c] = 0; m_mir[c] = 0; m_ext[c] = 0; m_aux[c] = 0;
      end
      m_mode = 0; m_rd = 0; m_itest = 0; m_good = 0;
    end else begin
      bit wm;
      if (rd_en) m_rd = m_read(int'(addr));
      wm = wr_en && addr == 3'd4;
      for (int c = 0; c < 2; c++) begin
        bit wc, ws, wa;
        int fp;
        wc = wr_en && addr == 3'(2*c);
        ws = wr_en && addr == 3'(2*c+1);
        wa = wr_en && addr == 3'(5+c);
        fp = (c == 0) ? 1 : 4;
        if (wc) m_cmd[c] = wr_data;
        m_irq[c] = irq_evt[c] || (m_irq[c] && !(ws && wr_data[2]));
        m_err[c] = err_evt[c] || (m_err[c] && !(ws && wr_data[1]));
        if (ws) m_cap[c] = wr_data[6:5];
        m_act[c] = xfer_active[c];
        m_off[c] = chan_off[c];
        m_mir[c] = irq_evt[c] || (m_mir[c] && !(wm && wr_data[2+c]));
        m_ext[c] = irq_evt[c] || (m_ext[c] && !(wa && wr_data[fp]));
        if (wa) m_aux[c] = wr_data & ~(8'd1 << fp);
        m_itest[c] = m_mir[c] && m_irq[c];
        m_good[c]  = m_irq[c] && !m_err[c] && !xfer_active[c];
      end
      if (wm) m_mode = wr_data & 8'hF1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R1 run", int'(run), int'({m_cmd[1][0], m_cmd[0][0]}));
      chk("R8 irq_test", int'(irq_test), int'(m_itest));
      chk("R9 xfer_good", int'(xfer_good), int'(m_good));
      chk("R11 rd_data", int'(rd_data), int'(m_rd));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(int a, int exp, string req);
    @(negedge clk);
    rd_en = 1; addr = 3'(a);
    @(negedge clk);
    rd_en = 0;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic pulse(bit irq, bit err, int c);
    @(negedge clk);
    irq_evt[c] = irq; err_evt[c] = err;
    @(negedge clk);
    irq_evt = '0; err_evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R10: everything reads zero after reset
    chk("R10 run", int'(run), 0);
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R10");

    // R1
    wr(0, 8'h01);
    chk("R1", int'(run), 1);
    rd_chk(0, 8'h01, "R1");
    wr(0, 8'h00);
    chk("R1", int'(run), 0);

    // R2 R5 R7 R8 R9 set paths
    pulse(1, 0, 0);
    chk("R8", int'(irq_test[0]), 1);
    chk("R9", int'(xfer_good[0]), 1);
    rd_chk(1, 8'h04, "R2");
    rd_chk(4, 8'h04, "R5");
    rd_chk(5, 8'h02, "R7");

    // R2 clear status only; mirror stays
    wr(1, 8'h04);
    chk("R8", int'(irq_test[0]), 0);
    rd_chk(1, 8'h00, "R2");
    rd_chk(4, 8'h04, "R5");

    // R3 set vs clear on one edge
    @(negedge clk);
    wr_en = 1; addr = 3'd1; wr_data = 8'h04; irq_evt[0] = 1;
    @(negedge clk);
    wr_en = 0; irq_evt = '0;
    rd_chk(1, 8'h04, "R3");

    // R2 R9 error
    pulse(0, 1, 0);
    chk("R9", int'(xfer_good[0]), 0);
    rd_chk(1, 8'h06, "R2");
    wr(1, 8'h02);
    rd_chk(1, 8'h04, "R2");

    // R4 capability and ignored bits
    wr(1, 8'h60);
    rd_chk(1, 8'h64, "R4");
    wr(1, 8'h9B);
    rd_chk(1, 8'h04, "R4");
    @(negedge clk);
    chan_off[1] = 1; xfer_active[1] = 1;
    rd_chk(3, 8'h81, "R4");

    // R6 mode byte
    wr(4, 8'hFF);
    rd_chk(4, 8'hF1, "R6");
    wr(4, 8'h00);
    rd_chk(4, 8'h00, "R6");

    // channel 1 interrupt with active transfer
    pulse(1, 0, 1);
    chk("R8", int'(irq_test[1]), 1);
    chk("R9", int'(xfer_good[1]), 0);
    rd_chk(3, 8'h85, "R2");
    rd_chk(4, 8'h08, "R5");
    rd_chk(6, 8'h10, "R7");

    // R7 aux clear with other bits writable
    wr(5, 8'hFF);
    rd_chk(5, 8'hFD, "R7");
    wr(5, 8'h00);
    rd_chk(5, 8'h00, "R7");

    // R8 mirror cleared, status flag still set
    wr(4, 8'h08);
    chk("R8", int'(irq_test[1]), 0);
    rd_chk(3, 8'h85, "R8");

    // R11 unmapped
    rd_chk(7, 8'h00, "R11");

    // random phase, model compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en       = ($urandom_range(0, 3) == 0);
      rd_en       = ($urandom_range(0, 1) == 0);
      addr        = 3'($urandom_range(0, 7));
      wr_data     = 8'($urandom);
      irq_evt     = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
      err_evt     = {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
      if ($urandom_range(0, 9) == 0) xfer_active = 2'($urandom);
      if ($urandom_range(0, 19) == 0) chan_off = 2'($urandom);
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; irq_evt = '0; err_evt = '0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule